// File: doc/BRIEF.md
# PS/2 Key Matrix Scanner

This block keeps a home-computer style keyboard matrix of 8 rows by 5 columns up to date from a stream of complete PS/2 set-2 scancode bytes. A break prefix byte turns the following code into a key release; any other mapped code marks its key as held. Serial reception of the PS/2 line is handled elsewhere. One byte arrives with a one-clock `code_valid` strobe.

The CPU reads the keyboard through the high byte of its port address. Each zero bit in that byte selects one row. The 5-bit active-low answer merges every selected row, so a key held in any selected row pulls its column low. The answer is registered only on clock cycles where the CPU clock enable is high, so reads follow the CPU at whatever speed it is running. A set of function keys is also decoded into system control strobes: a CPU reset, an unlock pulse for the memory paging registers, a CPU speed selection and an NMI request.

Top module: `kbd_matrix_scan`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `col_out` is 5'h1F and `sys_reset`, `unlock_pulse`, `speed_valid` and `nmi_req` are all 0; every key reads as released.
- R2: A mapped make code marks its key as held. Rows and columns count from 0, and column c is bit c of `col_out`. The codes used here are 0x1C (row 1 column 0), 0x1A (row 0 column 1), 0x29 (row 7 column 0), 0x32 (row 7 column 4) and 0x2E (row 3 column 4).
- R3: The byte 0xF0 arms a release. The next byte that is not 0xF0 consumes the armed state. If that byte is a mapped key code, its key is marked released.
- R4: Row r is selected when `addr_hi[r]` is 0. On an enabled cycle `col_out` becomes the bitwise AND of the active-low column data of all selected rows. With no row selected, it is 5'h1F.
- R5: `col_out` changes only at a clock edge where `cpu_ce` is high. That edge samples `addr_hi` and the key state as they stood before the edge.
- R6: A byte that is neither 0xF0 nor a mapped key code leaves the key state unchanged.
- R7: A make of F12 (0x07) drives `sys_reset` high for exactly RST_HOLD clocks, starting at the edge that takes the byte. Another F12 make reloads the full window.
- R8: A make of F9 (0x01) gives a one-clock `unlock_pulse` at the edge that takes the byte.
- R9: A make of F5 (0x03), F6 (0x0B), F7 (0x83) or F8 (0x0A) gives a one-clock `speed_valid`, with `speed_sel` set to 0, 1, 2 or 3 respectively. At most one of `unlock_pulse`, `speed_valid` and `nmi_req` is high in any cycle.
- R10: A make of F1 (0x05), F2 (0x06), F3 (0x04) or F4 (0x0C) gives a one-clock `nmi_req`.
- R11: A function key code that follows an armed release produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_byte | input | 8 | Received scancode byte |
| code_valid | input | 1 | One-clock strobe qualifying `code_byte` |
| addr_hi | input | 8 | CPU port address high byte; a 0 bit selects a row |
| cpu_ce | input | 1 | CPU clock enable |
| col_out | output | 5 | Active-low merged column data |
| sys_reset | output | 1 | CPU reset request, held RST_HOLD clocks |
| unlock_pulse | output | 1 | Paging-register unlock strobe |
| speed_valid | output | 1 | Speed selection strobe |
| speed_sel | output | 2 | Selected speed code, valid with `speed_valid` |
| nmi_req | output | 1 | NMI request strobe |

## Verification
The bench builds the block with RST_HOLD set to 6 instead of 16. This lets both the full reset window and its retrigger be observed within a few cycles of the reference model. The matrix geometry keeps its fixed 8 by 5 shape, so multi-row merges, the case with no row selected and the case with every row selected all fall inside the address patterns the bench drives. The CPU enable is run continuously, held off for a stretch, and pulsed every third clock. This exposes the hold behaviour of the registered read result at several enable rates.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KROWS = 8;
  localparam int KCOLS = 5;
  localparam logic [7:0] BREAK_PREFIX = 8'hF0;

  typedef struct packed {
    logic       hit;
    logic [2:0] row;
    logic [2:0] col;
  } key_pos_t;

  typedef enum logic [2:0] {FK_NONE, FK_RESET, FK_UNLOCK, FK_SPEED, FK_NMI} fkey_kind_t;

  typedef struct packed {
    fkey_kind_t kind;
    logic [1:0] arg;
  } fkey_t;

  function automatic key_pos_t mk(input int r, input int c);
    key_pos_t p;
    p.hit = 1'b1;
    p.row = 3'(r);
    p.col = 3'(c);
    return p;
  endfunction

  // Set-2 make code to matrix position.
  function automatic key_pos_t map_scancode(input logic [7:0] c);
    key_pos_t p;
    p = '0;
    case (c)
      8'h12: p = mk(0,0); 8'h1A: p = mk(0,1); 8'h22: p = mk(0,2); 8'h21: p = mk(0,3); 8'h2A: p = mk(0,4);
      8'h1C: p = mk(1,0); 8'h1B: p = mk(1,1); 8'h23: p = mk(1,2); 8'h2B: p = mk(1,3); 8'h34: p = mk(1,4);
      8'h15: p = mk(2,0); 8'h1D: p = mk(2,1); 8'h24: p = mk(2,2); 8'h2D: p = mk(2,3); 8'h2C: p = mk(2,4);
      8'h16: p = mk(3,0); 8'h1E: p = mk(3,1); 8'h26: p = mk(3,2); 8'h25: p = mk(3,3); 8'h2E: p = mk(3,4);
      8'h45: p = mk(4,0); 8'h46: p = mk(4,1); 8'h3E: p = mk(4,2); 8'h3D: p = mk(4,3); 8'h36: p = mk(4,4);
      8'h4D: p = mk(5,0); 8'h44: p = mk(5,1); 8'h43: p = mk(5,2); 8'h3C: p = mk(5,3); 8'h35: p = mk(5,4);
      8'h5A: p = mk(6,0); 8'h4B: p = mk(6,1); 8'h42: p = mk(6,2); 8'h3B: p = mk(6,3); 8'h33: p = mk(6,4);
      8'h29: p = mk(7,0); 8'h59: p = mk(7,1); 8'h3A: p = mk(7,2); 8'h31: p = mk(7,3); 8'h32: p = mk(7,4);
      default: p = '0;
    endcase
    return p;
  endfunction

  // Function key code to control action.
  function automatic fkey_t map_fkey(input logic [7:0] c);
    fkey_t f;
    f.kind = FK_NONE;
    f.arg  = 2'd0;
    case (c)
      8'h07: f.kind = FK_RESET;
      8'h01: f.kind = FK_UNLOCK;
      8'h03: begin f.kind = FK_SPEED; f.arg = 2'd0; end
      8'h0B: begin f.kind = FK_SPEED; f.arg = 2'd1; end
      8'h83: begin f.kind = FK_SPEED; f.arg = 2'd2; end
      8'h0A: begin f.kind = FK_SPEED; f.arg = 2'd3; end
      8'h05, 8'h06, 8'h04, 8'h0C: f.kind = FK_NMI;
      default: f.kind = FK_NONE;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/kbd_code_decoder.sv
module kbd_code_decoder
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] code_byte,
  input  logic       code_valid,
  output logic       key_ev,
  output logic [2:0] key_row,
  output logic [2:0] key_col,
  output logic       key_press,
  output logic       fk_ev,
  output fkey_t      fk,
  output logic       break_armed
);
  key_pos_t pos;
  logic     is_prefix;

  always_comb begin
    pos       = map_scancode(code_byte);
    fk        = map_fkey(code_byte);
    is_prefix = (code_byte == BREAK_PREFIX);
    key_ev    = code_valid && !is_prefix && pos.hit;
    key_row   = pos.row;
    key_col   = pos.col;
    key_press = !break_armed;
    fk_ev     = code_valid && !is_prefix && !break_armed && (fk.kind != FK_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          break_armed <= 1'b0;
    else if (code_valid) break_armed <= is_prefix;
  end

  // R3: an armed release is consumed by the next non-prefix byte
  assert_break_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !is_prefix) |=> !break_armed);
endmodule

// File: rtl/kbd_key_matrix.sv
module kbd_key_matrix #(
  parameter int ROWS = 8,
  parameter int COLS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_ev,
  input  logic [2:0]      key_row,
  input  logic [2:0]      key_col,
  input  logic            key_press,
  input  logic [ROWS-1:0] row_sel_n,
  input  logic            cpu_ce,
  output logic [COLS-1:0] col_out
);
  logic [ROWS-1:0][COLS-1:0] held;
  logic [ROWS-1:0][COLS-1:0] row_lo;
  logic [COLS-1:0]           merged;

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n) held[r] <= '0;
        else if (key_ev && (32'(key_row) == r)) held[r][key_col] <= key_press;
      end
      // active-low column data, forced high when row not selected
      assign row_lo[r] = row_sel_n[r] ? {COLS{1'b1}} : ~held[r];
    end
  endgenerate

  always_comb begin
    merged = {COLS{1'b1}};
    for (int i = 0; i < ROWS; i++) merged = merged & row_lo[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      col_out <= {COLS{1'b1}};
    else if (cpu_ce) col_out <= merged;
  end

  // R5: no enable, no change
  assert_col_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> $stable(col_out));
  // R6: key state moves only on a mapped key event
  assert_state_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ev |=> $stable(held));
endmodule

// File: rtl/kbd_ctrl_strobes.sv
module kbd_ctrl_strobes
  import kbd_pkg::*;
#(
  parameter int RST_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fk_ev,
  input  fkey_t      fk,
  output logic       sys_reset,
  output logic       unlock_pulse,
  output logic       speed_valid,
  output logic [1:0] speed_sel,
  output logic       nmi_req
);
  localparam int CW = $clog2(RST_HOLD + 1);
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt     <= '0;
      unlock_pulse <= 1'b0;
      speed_valid  <= 1'b0;
      speed_sel    <= 2'd0;
      nmi_req      <= 1'b0;
    end else begin
      unlock_pulse <= fk_ev && (fk.kind == FK_UNLOCK);
      speed_valid  <= fk_ev && (fk.kind == FK_SPEED);
      nmi_req      <= fk_ev && (fk.kind == FK_NMI);
      if (fk_ev && (fk.kind == FK_SPEED)) speed_sel <= fk.arg;
      if (fk_ev && (fk.kind == FK_RESET)) hold_cnt <= CW'(RST_HOLD);
      else if (hold_cnt != '0)            hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign sys_reset = (hold_cnt != '0);

  // R7: a reset request never collapses after one clock
  assert_reset_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) |=> sys_reset);
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int RST_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] code_byte,
  input  logic       code_valid,
  input  logic [7:0] addr_hi,
  input  logic       cpu_ce,
  output logic [4:0] col_out,
  output logic       sys_reset,
  output logic       unlock_pulse,
  output logic       speed_valid,
  output logic [1:0] speed_sel,
  output logic       nmi_req
);
  import kbd_pkg::*;

  logic       key_ev, key_press, fk_ev, break_armed;
  logic [2:0] key_row, key_col;
  fkey_t      fk;

  kbd_code_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .code_byte(code_byte), .code_valid(code_valid),
    .key_ev(key_ev), .key_row(key_row), .key_col(key_col), .key_press(key_press),
    .fk_ev(fk_ev), .fk(fk), .break_armed(break_armed)
  );

  kbd_key_matrix #(.ROWS(KROWS), .COLS(KCOLS)) u_mat (
    .clk(clk), .rst_n(rst_n), .key_ev(key_ev), .key_row(key_row), .key_col(key_col),
    .key_press(key_press), .row_sel_n(addr_hi), .cpu_ce(cpu_ce), .col_out(col_out)
  );

  kbd_ctrl_strobes #(.RST_HOLD(RST_HOLD)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fk_ev(fk_ev), .fk(fk), .sys_reset(sys_reset),
    .unlock_pulse(unlock_pulse), .speed_valid(speed_valid), .speed_sel(speed_sel),
    .nmi_req(nmi_req)
  );

  // R4: no row selected reads all released
  assert_no_row_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && (&addr_hi)) |=> (col_out == 5'h1F));
  // R9: control strobes are mutually exclusive
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock_pulse, speed_valid, nmi_req}));
  // R10: an NMI request always follows a received byte
  assert_nmi_from_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(code_valid));
  // R8: unlock only from the F9 code
  assert_unlock_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |-> ($past(code_byte) == 8'h01));
  // R11: no strobe from a byte that followed an armed release
  assert_break_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && break_armed) |=> !(unlock_pulse || speed_valid || nmi_req));
endmodule

// File: tb/kbd_matrix_scan_bench.sv
`timescale 1ns/1ps
module kbd_matrix_scan_bench;
  localparam int HOLD = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] code_byte = 8'h00;
  logic code_valid = 1'b0;
  logic [7:0] addr_hi = 8'hFF;
  logic cpu_ce = 1'b0;
  logic [4:0] col_out;
  logic sys_reset, unlock_pulse, speed_valid, nmi_req;
  logic [1:0] speed_sel;

  always #2.5 clk = ~clk;

  kbd_matrix_scan #(.RST_HOLD(HOLD)) u_kbd_matrix_scan (
    .clk(clk), .rst_n(rst_n), .code_byte(code_byte), .code_valid(code_valid),
    .addr_hi(addr_hi), .cpu_ce(cpu_ce), .col_out(col_out), .sys_reset(sys_reset),
    .unlock_pulse(unlock_pulse), .speed_valid(speed_valid), .speed_sel(speed_sel),
    .nmi_req(nmi_req)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // reference model: key positions as an associative table (index = row*5+col)
  int key_at[byte unsigned];
  bit m_keys[40];
  bit m_brk;
  int m_col, m_rcnt, m_spd_sel;
  bit m_unl, m_spd, m_nmi;

  initial begin
    key_at[8'h1C] = 5;  key_at[8'h1A] = 1;  key_at[8'h29] = 35;
    key_at[8'h32] = 39; key_at[8'h2E] = 19;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_keys[i]) m_keys[i] = 0;
      m_brk = 0; m_col = 'h1F; m_rcnt = 0; m_spd_sel = 0;
      m_unl = 0; m_spd = 0; m_nmi = 0;
    end else begin
      if (cpu_ce) begin
        m_col = 'h1F;
        for (int r = 0; r < 8; r++)
          if (!addr_hi[r])
            for (int c = 0; c < 5; c++)
              if (m_keys[r*5+c]) m_col = m_col & ~(1 << c);
      end
      m_unl = 0; m_spd = 0; m_nmi = 0;
      if (m_rcnt > 0) m_rcnt--;
      if (code_valid) begin
        if (code_byte == 8'hF0) m_brk = 1;
        else begin
          if (key_at.exists(code_byte)) m_keys[key_at[code_byte]] = !m_brk;
          if (!m_brk) begin
            case (code_byte)
              8'h07: m_rcnt = HOLD;
              8'h01: m_unl = 1;
              8'h03: begin m_spd = 1; m_spd_sel = 0; end
              8'h0B: begin m_spd = 1; m_spd_sel = 1; end
              8'h83: begin m_spd = 1; m_spd_sel = 2; end
              8'h0A: begin m_spd = 1; m_spd_sel = 3; end
              8'h05, 8'h06, 8'h04, 8'h0C: m_nmi = 1;
              default: ;
            endcase
          end
          m_brk = 0;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4/R5 col_out", col_out, m_col);
      chk("R7 sys_reset", sys_reset, m_rcnt != 0);
      chk("R8 unlock_pulse", unlock_pulse, m_unl);
      chk("R9 speed_valid", speed_valid, m_spd);
      if (m_spd) chk("R9 speed_sel", speed_sel, m_spd_sel);
      chk("R10 nmi_req", nmi_req, m_nmi);
    end
  end

  int ce_mode = 0;
  int ce_cnt = 0;
  always @(negedge clk) begin
    ce_cnt++;
    cpu_ce = (ce_mode != 0) && ((ce_cnt % (ce_mode == 0 ? 1 : ce_mode)) == 0);
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    code_byte = b; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    fork
      begin
        idle(3);
        chk("R1 col_out in reset", col_out, 'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 col_out after reset", col_out, 'h1F);
        chk("R1 strobes after reset", {sys_reset, unlock_pulse, speed_valid, nmi_req}, 0);
        ce_mode = 1;
        send(8'h1C); addr_hi = 8'hFD; idle(2);
        chk("R2 key 0x1C row1 col0", col_out, 'h1E);
        send(8'h1A); addr_hi = 8'hFC; idle(2);
        chk("R4 merge rows 0,1", col_out, 'h1C);
        addr_hi = 8'h7E; idle(2);
        chk("R4 merge rows 0,7", col_out, 'h1D);
        addr_hi = 8'h00; idle(2);
        chk("R4 all rows", col_out, 'h1C);
        addr_hi = 8'hFF; idle(2);
        chk("R4 no row", col_out, 'h1F);
        addr_hi = 8'hFC;
        send(8'h70); send(8'hE0); idle(2);
        chk("R6 unmapped codes", col_out, 'h1C);
        send(8'hF0); send(8'h1C); idle(2);
        chk("R3 release 0x1C", col_out, 'h1D);
        send(8'hF0); send(8'h07);
        chk("R11 F12 break no reset", sys_reset, 0);
        send(8'hF0); send(8'h05);
        chk("R11 F1 break no nmi", nmi_req, 0);
        send(8'h07);
        chk("R7 reset raised", sys_reset, 1);
        idle(2); send(8'h07); idle(HOLD - 2);
        chk("R7 reset retriggered", sys_reset, 1);
        idle(2);
        chk("R7 reset released", sys_reset, 0);
        send(8'h01);
        chk("R8 unlock", unlock_pulse, 1);
        send(8'h83);
        chk("R9 F7 sel", {speed_valid, speed_sel}, 'b110);
        send(8'h03); send(8'h0B); send(8'h0A);
        send(8'h06);
        chk("R10 F2 nmi", nmi_req, 1);
        send(8'h04); send(8'h0C); send(8'h05);
        addr_hi = 8'h7F; idle(2);
        chk("R5 row7 idle", col_out, 'h1F);
        ce_mode = 0;
        send(8'h29); idle(3);
        chk("R5 held without enable", col_out, 'h1F);
        ce_mode = 1; idle(2);
        chk("R5 updated on enable", col_out, 'h1E);
        ce_mode = 3;
        for (int i = 0; i < 400; i++) begin
          int pick;
          pick = $urandom_range(0, 11);
          addr_hi = 8'($urandom);
          case (pick)
            0: send(8'hF0); 1: send(8'h1C); 2: send(8'h1A); 3: send(8'h29);
            4: send(8'h32); 5: send(8'h2E); 6: send(8'h70); 7: send(8'h07);
            8: send(8'h01); 9: send(8'h0B); 10: send(8'h06);
            default: idle(1);
          endcase
        end
        idle(HOLD + 4);
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule